// File: doc/BRIEF.md
# Status Snapshot Packet Streamer

This block returns a fixed-length status report to a host through the write side of a synchronous 32-bit FIFO-style USB bridge. A command decoder in the system clock domain watches for either of two request opcodes. A match flips a request toggle. The toggle crosses into the bridge clock domain through a flop synchronizer, and an edge detector there turns each flip into a single start event.

On a start event the block captures a snapshot of its configuration and self-test inputs into six packed status words. It then writes an eight-word packet: a header, the six snapshot words and a footer. The write strobe and the word index are held for as long as the bridge signals that it cannot take data. After the footer the control spends one settle cycle and then returns to idle.

Top module: `status_pkt_streamer`

## Requirements
- R1: While `rstN` is low and after it is released, `txWrite` stays 0 until a status request has been accepted.
- R2: A one-cycle `cmdValid` with `cmdOpcode` = 0xFF in the system clock domain starts exactly one packet in the bridge clock domain.
- R3: A one-cycle `cmdValid` with `cmdOpcode` = 0x31 starts the same packet as 0xFF.
- R4: A command with any other opcode, for example 0x30, 0xFE or 0x00, produces no write.
- R5: A packet is exactly 8 accepted words in this order: 0x000000BB, status words 0 to 5, then 0x00000055. Status word 1 is `cfgAuxA` and status word 2 is `cfgAuxB`, both unchanged.
- R6: Status word 0 has 0xFF in bits [31:24], 0 in bit 23, `cfgMode` in [22:21], 0 in [20:19], `cfgStreamCtrl` in [18:16] and `cfgThreshold` in [15:0].
- R7: Status word 3 has `cfgListen` in [31:16], zeros in [15:6] and `cfgChirps` in [5:0]. Status word 4 has zeros in [31:2] and `cfgRangeMode` in [1:0].
- R8: Status word 5 has `stBusy` in bit 24, `stDetail` in [15:8] and `stFlags` in [4:0], with every other bit 0.
- R9: While `txBlocked` stays low, the 8 words go out with `txWrite` high on 8 consecutive bridge cycles.
- R10: While `txBlocked` is high, `txWrite` stays high and `txData` holds its word. No word is skipped or repeated. A word counts as accepted at a rising `brgClk` edge where `txWrite` is 1 and `txBlocked` is 0.
- R11: The packet carries the input values present when the request was taken. Input changes after the first word is presented do not alter any word of that packet.
- R12: A request whose edge reaches the bridge domain while a packet is in flight is discarded. Only one packet is sent, and `txWrite` returns to 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low asynchronous reset for both clock domains |
| sysClk | input | 1 | System clock (command side) |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOpcode | input | 8 | Command opcode, sampled while cmdValid is high |
| brgClk | input | 1 | Bridge clock (write side) |
| txBlocked | input | 1 | High when the bridge cannot accept a word |
| txWrite | output | 1 | Word on txData is offered to the bridge |
| txData | output | 32 | Packet word |
| cfgThreshold | input | 16 | Detection threshold |
| cfgStreamCtrl | input | 3 | Stream enable bits |
| cfgMode | input | 2 | Operating mode |
| cfgAuxA | input | 32 | Status word 1 content |
| cfgAuxB | input | 32 | Status word 2 content |
| cfgListen | input | 16 | Short listen duration |
| cfgChirps | input | 6 | Chirps per elevation step |
| cfgRangeMode | input | 2 | Range mode |
| stFlags | input | 5 | Pass bit per self-test |
| stDetail | input | 8 | Self-test detail code |
| stBusy | input | 1 | Self-test in progress |

## Verification
The packet is requested with both opcodes, using two input sets that differ in every field: all-pass self-test flags with the busy bit clear, then a partial-failure flag pattern with the busy bit set. This separates the two opcodes and exposes any misplaced field in the packing. Rejected opcodes next to the valid ones show that the decoder does not match too loosely. An irregular blocked/open pattern on `txBlocked` distinguishes holding the word from skipping or repeating it. Changing the inputs in mid-packet, and issuing a second request in mid-packet, show that the snapshot is frozen and that a late request is dropped.

// File: rtl/status_pkt_pkg.sv
package status_pkt_pkg;
  localparam int WORD_W   = 32;
  localparam int N_STATUS = 6;
  localparam int PKT_LEN  = N_STATUS + 2;
  localparam int IDX_W    = $clog2(PKT_LEN);
  localparam logic [WORD_W-1:0] HEADER_WORD = 32'h0000_00BB;
  localparam logic [WORD_W-1:0] FOOTER_WORD = 32'h0000_0055;
  localparam logic [IDX_W-1:0]  LAST_IDX    = IDX_W'(PKT_LEN - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } pktState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             inSend;
    logic [IDX_W-1:0] wordIdx;
  } pktStrobe_t;

  // Live inputs that feed the snapshot
  typedef struct packed {
    logic [15:0] threshold;
    logic [2:0]  streamCtrl;
    logic [1:0]  mode;
    logic [31:0] auxA;
    logic [31:0] auxB;
    logic [15:0] listen;
    logic [5:0]  chirps;
    logic [1:0]  rangeMode;
    logic [4:0]  flags;
    logic [7:0]  detail;
    logic        busy;
  } statusIn_t;
endpackage

// File: rtl/status_req_cross.sv
module status_req_cross #(
  parameter logic [7:0] OP_PRIMARY  = 8'hFF,
  parameter logic [7:0] OP_ALIAS    = 8'h31,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       rstN,
  input  logic       sysClk,
  input  logic       cmdValid,
  input  logic [7:0] cmdOpcode,
  input  logic       brgClk,
  output logic       reqEdge
);
  logic cmdHit;
  logic reqToggle;
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncPrev;

  assign cmdHit = cmdValid && ((cmdOpcode == OP_PRIMARY) || (cmdOpcode == OP_ALIAS));

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) reqToggle <= 1'b0;
    else if (cmdHit) reqToggle <= ~reqToggle;
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge brgClk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= reqToggle;
        end
      end else begin : g_next
        always_ff @(posedge brgClk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge brgClk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[SYNC_STAGES-1];
  end

  assign reqEdge = syncChain[SYNC_STAGES-1] ^ syncPrev;

  // R2
  toggle_flip_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    cmdHit |=> (reqToggle != $past(reqToggle)));
  // R4
  toggle_idle_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !cmdHit |=> $stable(reqToggle));
endmodule

// File: rtl/status_pkt_ctrl.sv
module status_pkt_ctrl
  import status_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqEdge,
  input  logic       txBlocked,
  output pktStrobe_t strb
);
  pktState_t        state;
  logic [IDX_W-1:0] wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqEdge) begin
          state   <= ST_SEND;
          wordIdx <= '0;
        end
        ST_SEND: if (!txBlocked) begin
          if (wordIdx == LAST_IDX) state <= ST_WAIT;
          else wordIdx <= wordIdx + 1'b1;
        end
        ST_WAIT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && reqEdge;
    strb.inSend  = (state == ST_SEND);
    strb.wordIdx = wordIdx;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && txBlocked) |=> (state == ST_SEND && $stable(wordIdx)));
  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !txBlocked && wordIdx != LAST_IDX) |=>
      (state == ST_SEND && wordIdx == $past(wordIdx) + 1'b1));
  // R5
  last_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !txBlocked && wordIdx == LAST_IDX) |=> (state == ST_WAIT));
  // R12
  wait_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |=> (state == ST_IDLE));
endmodule

// File: rtl/status_pkt_datapath.sv
module status_pkt_datapath
  import status_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pktStrobe_t        strb,
  input  statusIn_t         stIn,
  output logic [WORD_W-1:0] txData
);
  logic [N_STATUS-1:0][WORD_W-1:0] liveWords;
  logic [N_STATUS-1:0][WORD_W-1:0] snapWords;
  logic [PKT_LEN-1:0][WORD_W-1:0]  pktWords;

  always_comb begin
    liveWords[0] = {8'hFF, 1'b0, stIn.mode, 2'b00, stIn.streamCtrl, stIn.threshold};
    liveWords[1] = stIn.auxA;
    liveWords[2] = stIn.auxB;
    liveWords[3] = {stIn.listen, 10'd0, stIn.chirps};
    liveWords[4] = {30'd0, stIn.rangeMode};
    liveWords[5] = {7'd0, stIn.busy, 8'd0, stIn.detail, 3'd0, stIn.flags};
  end

  genvar w;
  generate
    for (w = 0; w < N_STATUS; w++) begin : g_snap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             snapWords[w] <= '0;
        else if (strb.capture) snapWords[w] <= liveWords[w];
      end
      assign pktWords[w+1] = snapWords[w];
    end
  endgenerate

  assign pktWords[0]         = HEADER_WORD;
  assign pktWords[PKT_LEN-1] = FOOTER_WORD;
  assign txData              = pktWords[strb.wordIdx];

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inSend |=> $stable(snapWords));
endmodule

// File: rtl/status_pkt_streamer.sv
module status_pkt_streamer
  import status_pkt_pkg::*;
(
  input  logic        rstN,
  input  logic        sysClk,
  input  logic        cmdValid,
  input  logic [7:0]  cmdOpcode,
  input  logic        brgClk,
  input  logic        txBlocked,
  output logic        txWrite,
  output logic [31:0] txData,
  input  logic [15:0] cfgThreshold,
  input  logic [2:0]  cfgStreamCtrl,
  input  logic [1:0]  cfgMode,
  input  logic [31:0] cfgAuxA,
  input  logic [31:0] cfgAuxB,
  input  logic [15:0] cfgListen,
  input  logic [5:0]  cfgChirps,
  input  logic [1:0]  cfgRangeMode,
  input  logic [4:0]  stFlags,
  input  logic [7:0]  stDetail,
  input  logic        stBusy
);
  logic       reqEdge;
  pktStrobe_t strb;
  statusIn_t  stIn;

  always_comb begin
    stIn.threshold  = cfgThreshold;
    stIn.streamCtrl = cfgStreamCtrl;
    stIn.mode       = cfgMode;
    stIn.auxA       = cfgAuxA;
    stIn.auxB       = cfgAuxB;
    stIn.listen     = cfgListen;
    stIn.chirps     = cfgChirps;
    stIn.rangeMode  = cfgRangeMode;
    stIn.flags      = stFlags;
    stIn.detail     = stDetail;
    stIn.busy       = stBusy;
  end

  status_req_cross #(.OP_PRIMARY(8'hFF), .OP_ALIAS(8'h31), .SYNC_STAGES(2)) u_cross (
    .rstN(rstN), .sysClk(sysClk), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .brgClk(brgClk), .reqEdge(reqEdge));

  status_pkt_ctrl u_ctrl (
    .clk(brgClk), .rstN(rstN), .reqEdge(reqEdge), .txBlocked(txBlocked), .strb(strb));

  status_pkt_datapath u_dp (
    .clk(brgClk), .rstN(rstN), .strb(strb), .stIn(stIn), .txData(txData));

  assign txWrite = strb.inSend;

  // R1
  reset_quiet_chk: assert property (@(posedge brgClk)
    !rstN |-> !txWrite);
endmodule

// File: tb/status_pkt_streamer_bench.sv
module status_pkt_streamer_bench;
  logic rstN = 1'b0;
  logic sysClk = 1'b0;
  logic brgClk = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdOpcode = 8'h00;
  logic txBlocked = 1'b0;
  logic txWrite;
  logic [31:0] txData;
  logic [15:0] cfgThreshold = '0;
  logic [2:0]  cfgStreamCtrl = '0;
  logic [1:0]  cfgMode = '0;
  logic [31:0] cfgAuxA = '0;
  logic [31:0] cfgAuxB = '0;
  logic [15:0] cfgListen = '0;
  logic [5:0]  cfgChirps = '0;
  logic [1:0]  cfgRangeMode = '0;
  logic [4:0]  stFlags = '0;
  logic [7:0]  stDetail = '0;
  logic        stBusy = 1'b0;

  always #10 sysClk = ~sysClk;   // 50 MHz
  always #7  brgClk = ~brgClk;

  status_pkt_streamer u_status_pkt_streamer (
    .rstN(rstN), .sysClk(sysClk), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .brgClk(brgClk), .txBlocked(txBlocked), .txWrite(txWrite), .txData(txData),
    .cfgThreshold(cfgThreshold), .cfgStreamCtrl(cfgStreamCtrl), .cfgMode(cfgMode),
    .cfgAuxA(cfgAuxA), .cfgAuxB(cfgAuxB), .cfgListen(cfgListen), .cfgChirps(cfgChirps),
    .cfgRangeMode(cfgRangeMode), .stFlags(stFlags), .stDetail(stDetail), .stBusy(stBusy));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] got [64];
  logic [31:0] expPkt [8];
  int wordCnt = 0;
  int runLen = 0;
  int lastRun = 0;
  bit prevStall = 0;
  logic [31:0] prevData = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Accepted-word monitor, sampled 1 ns after the falling bridge edge
  always @(negedge brgClk) begin
    #1;
    if (rstN) begin
      if (prevStall) begin
        check(txWrite === 1'b1, "R10 strobe held while blocked", {31'd0, txWrite}, 32'd1);
        check(txData === prevData, "R10 data held while blocked", txData, prevData);
      end
      prevStall = txWrite && txBlocked;
      prevData  = txData;
      if (txWrite) runLen++;
      else begin
        if (runLen != 0) lastRun = runLen;
        runLen = 0;
      end
      if (txWrite && !txBlocked) begin
        if (wordCnt < 64) got[wordCnt] = txData;
        wordCnt++;
      end
    end
  end

  task automatic clearMon();
    wordCnt = 0; runLen = 0; lastRun = 0; prevStall = 0;
  endtask

  task automatic snapExpected();
    expPkt[0] = 32'h0000_00BB;
    expPkt[1] = {8'hFF, 1'b0, cfgMode, 2'b00, cfgStreamCtrl, cfgThreshold};
    expPkt[2] = cfgAuxA;
    expPkt[3] = cfgAuxB;
    expPkt[4] = {cfgListen, 10'd0, cfgChirps};
    expPkt[5] = {30'd0, cfgRangeMode};
    expPkt[6] = {7'd0, stBusy, 8'd0, stDetail, 3'd0, stFlags};
    expPkt[7] = 32'h0000_0055;
  endtask

  task automatic issueCmd(input logic [7:0] op);
    @(negedge sysClk);
    cmdValid = 1'b1; cmdOpcode = op;
    @(negedge sysClk);
    cmdValid = 1'b0; cmdOpcode = 8'h00;
  endtask

  task automatic waitWords(input int n, input string tag);
    int guard = 0;
    while (wordCnt < n && guard < 400) begin
      @(negedge brgClk); guard++;
    end
    check(wordCnt >= n, tag, wordCnt, n);
  endtask

  task automatic waitWrite(input string tag);
    int guard = 0;
    do begin
      @(negedge brgClk); #2; guard++;
    end while (!txWrite && guard < 100);
    check(txWrite === 1'b1, tag, {31'd0, txWrite}, 32'd1);
  endtask

  task automatic comparePkt(input string tag);
    repeat (20) @(negedge brgClk);
    check(wordCnt == 8, {tag, " word count"}, wordCnt, 8);
    for (int i = 0; i < 8; i++)
      check(got[i] === expPkt[i], $sformatf("%s word %0d", tag, i), got[i], expPkt[i]);
    check(txWrite === 1'b0, {tag, " idle after packet"}, {31'd0, txWrite}, 32'd0);
  endtask

  task automatic setPatternA();
    cfgThreshold = 16'h1234; cfgStreamCtrl = 3'b101; cfgMode = 2'b10;
    cfgAuxA = 32'hDEAD_BEEF; cfgAuxB = 32'h0BAD_F00D;
    cfgListen = 16'd17450; cfgChirps = 6'd32; cfgRangeMode = 2'b10;
    stFlags = 5'b11111; stDetail = 8'hA5; stBusy = 1'b0;
  endtask

  task automatic setPatternB();
    cfgThreshold = 16'hFEDC; cfgStreamCtrl = 3'b010; cfgMode = 2'b01;
    cfgAuxA = 32'h1357_9BDF; cfgAuxB = 32'h2468_ACE0;
    cfgListen = 16'hC001; cfgChirps = 6'h3F; cfgRangeMode = 2'b11;
    stFlags = 5'b10110; stDetail = 8'h42; stBusy = 1'b1;
  endtask

  task automatic testReset();
    // R1
    check(txWrite === 1'b0, "R1 no write in reset", {31'd0, txWrite}, 32'd0);
    @(negedge sysClk); rstN = 1'b1;
    repeat (20) @(negedge brgClk);
    check(wordCnt == 0, "R1 no words after reset", wordCnt, 0);
  endtask

  task automatic testPrimary();
    // R2 R5 R6 R7 R8 R9
    clearMon(); setPatternA(); snapExpected();
    issueCmd(8'hFF);
    waitWords(8, "R2 packet from 0xFF");
    comparePkt("R5 R6 R7 R8 primary");
    check(lastRun == 8, "R9 eight consecutive writes", lastRun, 8);
  endtask

  task automatic testAlias();
    // R3 R8
    clearMon(); setPatternB(); snapExpected();
    issueCmd(8'h31);
    waitWords(8, "R3 packet from 0x31");
    comparePkt("R3 R8 alias busy");
    check(lastRun == 8, "R9 alias consecutive writes", lastRun, 8);
  endtask

  task automatic testIgnored();
    // R4
    clearMon();
    issueCmd(8'h30); issueCmd(8'hFE); issueCmd(8'h00);
    repeat (40) @(negedge brgClk);
    check(wordCnt == 0, "R4 other opcodes ignored", wordCnt, 0);
    check(txWrite === 1'b0, "R4 no strobe", {31'd0, txWrite}, 32'd0);
  endtask

  task automatic testStall();
    // R10
    clearMon(); setPatternA(); cfgAuxA = 32'h0F0F_0F0F; snapExpected();
    @(negedge brgClk); txBlocked = 1'b1;
    issueCmd(8'hFF);
    waitWrite("R10 packet presented");
    for (int i = 0; i < 60 && wordCnt < 8; i++) begin
      @(negedge brgClk);
      txBlocked = (i % 3 != 0);
    end
    @(negedge brgClk); txBlocked = 1'b0;
    waitWords(8, "R10 all words accepted");
    comparePkt("R10 stalled packet");
  endtask

  task automatic testSnapshot();
    // R11
    clearMon(); setPatternB(); snapExpected();
    @(negedge brgClk); txBlocked = 1'b1;
    issueCmd(8'h31);
    waitWrite("R11 packet presented");
    setPatternA();
    repeat (5) @(negedge brgClk);
    txBlocked = 1'b0;
    waitWords(8, "R11 all words accepted");
    comparePkt("R11 frozen snapshot");
  endtask

  task automatic testDrop();
    // R12
    clearMon(); setPatternA(); snapExpected();
    @(negedge brgClk); txBlocked = 1'b1;
    issueCmd(8'hFF);
    waitWrite("R12 packet presented");
    issueCmd(8'h31);
    repeat (20) @(negedge brgClk);
    txBlocked = 1'b0;
    waitWords(8, "R12 first packet done");
    repeat (40) @(negedge brgClk);
    check(wordCnt == 8, "R12 second request dropped", wordCnt, 8);
    check(txWrite === 1'b0, "R12 back to idle", {31'd0, txWrite}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sysClk);
    testReset();
    testPrimary();
    testAlias();
    testIgnored();
    testStall();
    testSnapshot();
    testDrop();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule